// File: doc/BRIEF.md
# Sticky Stereo Peak Level Monitor

This block watches a stereo stream of signed 20-bit samples. It reads the samples before any limiter, and a valid strobe marks each one. Every valid sample is sorted by its magnitude into one of eight loudness classes. The classes are: clipping, six 1 dB bands covering -1 dBFS down to -6 dBFS, and everything quieter than -6 dBFS. Each channel keeps the loudest class it has seen since its last read.

Software reads both classes at once by pulsing a read strobe. One cycle later the block presents a status byte that holds both 3-bit codes. The same strobe empties both fields, so every read reports the peak over the interval since the previous read. When a read and a sample arrive in the same cycle, the read returns the codes from before that sample. The sample's class then starts the new interval, so its peak is not lost.

Top module: `peak_level_monitor`

## Requirements
- R1: After reset, both level fields are 0, so a first read returns a status byte of 0x00.
- R2: Level codes: 0 means a magnitude below T6. Code 7-k (k = 1..6) means a magnitude of at least Tk that is below T(k-1) (band k = 1 has no upper bound other than clipping). Code 7 means clipping. Tk = round(10^(-k/20) * (2^19 - 1)), rounded to the nearest integer.
- R3: A sample equal to the largest positive code (2^19 - 1) or to the most negative code (-2^19) always gives code 7.
- R4: Negative samples are classified by their absolute value. The most negative code counts as full scale.
- R5: On each valid sample, a channel's stored code becomes the larger of its stored code and the sample's code. A quieter sample never lowers the field.
- R6: Sample inputs are ignored in cycles where the valid strobe is low.
- R7: One cycle after a read strobe, the read valid output is high for one cycle. Bits [2:0] of the status byte hold the left code, bits [5:3] hold the right code, and bits [7:6] read 0.
- R8: A read strobe without a valid sample clears both fields to 0.
- R9: When a read strobe and a valid sample fall in the same cycle, the read returns the codes held before that sample. Each field is then left holding the new sample's own code.
- R10: The left and right channels are classified and held independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 1 | A sample pair is present this cycle |
| smp_left | input | 20 | Left-channel sample, two's complement |
| smp_right | input | 20 | Right-channel sample, two's complement |
| rd_stb | input | 1 | Read strobe: capture and clear both fields |
| rd_valid | output | 1 | Status byte is valid this cycle |
| rd_data | output | 8 | Status byte: {2'b00, right code, left code} |

## Verification
A read strobe and a valid sample can land in the same cycle, so the clear-on-read and the max-update compete for the same fields. The bench first loads known codes into both channels. It then raises the read strobe and the valid strobe together, with a sample whose class differs from the held one, sometimes quieter and sometimes louder. The status byte from that read must show the pre-sample codes. A second read must then show exactly the new sample's codes, neither the old peak nor zero.

// File: rtl/plm_pkg.sv
package plm_pkg;

  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_STEPS = 6;

  typedef logic [CODE_W-1:0] lvl_code_t;

  localparam lvl_code_t CODE_QUIET = '0;
  localparam lvl_code_t CODE_CLIP  = lvl_code_t'(NUM_STEPS + 1);

  // Threshold for the band k dB below full scale, rounded to the nearest integer.
  function automatic longint unsigned step_threshold(input int unsigned width,
                                                     input int unsigned k);
    real full;
    real r;
    full = (2.0 ** (width - 1)) - 1.0;
    r    = full * (10.0 ** (-(real'(k)) / 20.0));
    return longint'($rtoi(r + 0.5));
  endfunction

endpackage

// File: rtl/plm_rst_sync.sv
module plm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/plm_classifier.sv
module plm_classifier
  import plm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 20
) (
  input  logic [SAMPLE_W-1:0] sample,
  output lvl_code_t           code,
  output logic                clip
);

  localparam logic [SAMPLE_W-1:0] MAX_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] MIN_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] magnitude;
  logic [NUM_STEPS:1]  at_least;

  // Unsigned magnitude: the most negative code maps to 2^(W-1) without overflow.
  always_comb begin
    if (sample[SAMPLE_W-1]) begin
      magnitude = (~sample) + 1'b1;
    end else begin
      magnitude = sample;
    end
  end

  for (genvar k = 1; k <= NUM_STEPS; k++) begin : g_step
    localparam logic [SAMPLE_W-1:0] THR = SAMPLE_W'(step_threshold(SAMPLE_W, k));
    assign at_least[k] = (magnitude >= THR);
  end

  always_comb begin
    clip = (sample == MAX_POS) || (sample == MIN_NEG);
  end

  // Thresholds fall with k, so the loudest band that is met wins.
  always_comb begin
    code = CODE_QUIET;
    for (int k = NUM_STEPS; k >= 1; k--) begin
      if (at_least[k]) begin
        code = lvl_code_t'(NUM_STEPS + 1 - k);
      end
    end
    if (clip) begin
      code = CODE_CLIP;
    end
  end

endmodule

// File: rtl/plm_hold.sv
module plm_hold
  import plm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_en,
  input  logic      clr_en,
  input  lvl_code_t new_code,
  output lvl_code_t held
);

  lvl_code_t held_q;
  lvl_code_t held_d;
  logic      held_en;

  always_comb begin
    held_en = upd_en | clr_en;
    held_d  = held_q;
    if (clr_en) begin
      held_d = upd_en ? new_code : CODE_QUIET;
    end else if (upd_en && (new_code > held_q)) begin
      held_d = new_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= CODE_QUIET;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  assign held = held_q;

  AST_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_en) |=> (held_q >= $past(held_q)) && (held_q >= $past(new_code))); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !clr_en) |=> $stable(held_q)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !upd_en) |=> (held_q == CODE_QUIET)); // R8
  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && upd_en) |=> (held_q == $past(new_code))); // R9

endmodule

// File: rtl/peak_level_monitor.sv
module peak_level_monitor
  import plm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 20,
  parameter int unsigned STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                rd_stb,
  output logic                rd_valid,
  output logic [STATUS_W-1:0] rd_data
);

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned PAD_W   = STATUS_W - NUM_CH * CODE_W;

  logic                 rst_n_sync;
  logic [SAMPLE_W-1:0]  ch_sample [NUM_CH];
  lvl_code_t            ch_code   [NUM_CH];
  logic                 ch_clip   [NUM_CH];
  lvl_code_t            ch_held   [NUM_CH];
  logic [STATUS_W-1:0]  status_d;
  logic [STATUS_W-1:0]  status_q;
  logic                 valid_q;

  plm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign ch_sample[0] = smp_left;
  assign ch_sample[1] = smp_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    plm_classifier #(.SAMPLE_W(SAMPLE_W)) u_cls (
      .sample (ch_sample[c]),
      .code   (ch_code[c]),
      .clip   (ch_clip[c])
    );
    plm_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .upd_en   (smp_vld),
      .clr_en   (rd_stb),
      .new_code (ch_code[c]),
      .held     (ch_held[c])
    );
  end

  always_comb begin
    status_d = {{PAD_W{1'b0}}, ch_held[1], ch_held[0]};
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      status_q <= '0;
    end else if (rd_stb) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_stb;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = status_q;

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rd_stb |=> rd_valid); // R7
  AST_READ_OLD_CODES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rd_stb |=> (rd_data == {{PAD_W{1'b0}}, $past(ch_held[1]), $past(ch_held[0])})); // R9
  AST_CLIP_LEFT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (smp_vld && ch_clip[0]) |=> (ch_held[0] == CODE_CLIP)); // R3
  AST_CLIP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (smp_vld && ch_clip[1]) |=> (ch_held[1] == CODE_CLIP)); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rd_valid |-> (rd_data[STATUS_W-1:NUM_CH*CODE_W] == '0)); // R7

endmodule

// File: tb/sim_peak_level_monitor.sv
module sim_peak_level_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 20;
  localparam longint MAXP = (64'sd1 <<< (SW - 1)) - 1;
  localparam longint MINN = -(64'sd1 <<< (SW - 1));

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_vld;
  logic [SW-1:0] smp_left;
  logic [SW-1:0] smp_right;
  logic          rd_stb;
  logic          rd_valid;
  logic [7:0]    rd_data;

  int checks = 0;
  int errors = 0;
  longint thr [1:6];

  always #(CLK_PERIOD/2) clk = ~clk;

  peak_level_monitor u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_left(smp_left),
    .smp_right(smp_right), .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic int exp_code(input longint v);
    longint mag;
    int c;
    if (v == MAXP || v == MINN) return 7;
    mag = (v < 0) ? -v : v;
    c = 0;
    for (int k = 6; k >= 1; k--) if (mag >= thr[k]) c = 7 - k;
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic send(input longint l, input longint r, input logic vld);
    @(negedge clk);
    smp_vld = vld; smp_left = SW'(l); smp_right = SW'(r);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic do_read(input string req, input int el, input int er);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check({req, " valid"}, 32'(rd_valid), 32'd1);
    check({req, " data"}, 32'(rd_data), 32'((er << 3) | el));
    @(negedge clk);
    check({req, " valid one cycle"}, 32'(rd_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint vals [$];
    for (int k = 1; k <= 6; k++)
      thr[k] = longint'($rtoi(real'(MAXP) * (10.0 ** (-(real'(k)) / 20.0)) + 0.5));
    rst_n = 1'b0; smp_vld = 1'b0; smp_left = '0; smp_right = '0; rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: first read after reset
    do_read("R1 reset", 0, 0);

    // R2 R3 R4 R10: boundary sweep, left and right get different values
    vals = '{0, 1, -1, MAXP, MAXP - 1, MINN, MINN + 1};
    for (int k = 1; k <= 6; k++) begin
      vals.push_back(thr[k] - 1); vals.push_back(thr[k]); vals.push_back(thr[k] + 1);
      vals.push_back(-(thr[k] - 1)); vals.push_back(-thr[k]); vals.push_back(-(thr[k] + 1));
    end
    for (int i = 0; i < vals.size(); i++) begin
      longint l = vals[i];
      longint r = vals[vals.size() - 1 - i];
      send(l, r, 1'b1);
      do_read("R2 R3 R4 R10 sweep", exp_code(l), exp_code(r));
    end

    // R5: loud then quiet keeps loud; quiet then loud rises
    send(thr[2], -thr[5], 1'b1);
    send(thr[6], thr[1], 1'b1);
    send(1, 5, 1'b1);
    do_read("R5 max hold", 5, 6);

    // R6: invalid samples ignored
    send(MAXP, MINN, 1'b0);
    do_read("R6 ignored", 0, 0);
    send(thr[4], thr[4], 1'b1);
    send(MAXP, MAXP, 1'b0);
    do_read("R6 ignored held", 3, 3);

    // R8: read clears
    send(thr[1], thr[3], 1'b1);
    do_read("R8 first", 6, 4);
    do_read("R8 cleared", 0, 0);

    // R9: read and sample in same cycle (quieter and louder new sample)
    for (int pass = 0; pass < 2; pass++) begin
      longint nl = pass ? MINN : thr[6];
      longint nr = pass ? thr[2] : 0;
      send(thr[3], thr[5], 1'b1);
      @(negedge clk);
      rd_stb = 1'b1; smp_vld = 1'b1; smp_left = SW'(nl); smp_right = SW'(nr);
      @(negedge clk);
      rd_stb = 1'b0; smp_vld = 1'b0;
      check("R9 collision valid", 32'(rd_valid), 32'd1);
      check("R9 collision old codes", 32'(rd_data), 32'((2 << 3) | 4));
      do_read("R9 new sample kept", exp_code(nl), exp_code(nr));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule